// File: doc/BRIEF.md
# Dual-Read General-Purpose Register File

This block is the integer register store of a small processor whose instructions are all 32 bits long and share a fixed layout. The store has 32 registers of 32 bits. The two read selects come from fixed bit positions of the instruction word, so the operands are read combinationally while the rest of the instruction is still being decoded. The write side is synchronous. Its target register is picked from the instruction by a 2-bit destination code. The code can choose the register-register destination field, the immediate-type target field, or the fixed link register that receives the return address on a jump-and-link.

Register 0 is a constant zero. It always reads as zero, and any write aimed at it is dropped. A write in progress is forwarded to a read of the same register in the same cycle. This lets a value written back in one stage be consumed by a read in the same clock without an extra bypass path outside the block.

Top module: `gpr_file`

## Requirements
- R1: The file holds 32 registers of 32 bits. Port `rs_data` combinationally shows the register selected by `instr[25:21]`, and port `rt_data` shows the register selected by `instr[20:16]`. Both ports read independently in the same cycle.
- R2: When a read select is 0, its port shows 0, whatever was written and whatever write is in progress.
- R3: A write whose selected destination is register 0 is discarded, and register 0 stays zero.
- R4: Destination code `dst_sel` = 2'b00 writes to the register given by `instr[15:11]`.
- R5: Destination code 2'b01 writes to the register given by `instr[20:16]`.
- R6: Destination code 2'b10 writes to register 31, whatever the instruction fields hold.
- R7: Destination code 2'b11 performs no write, even with `wr_en` high.
- R8: A write stores `wr_data` at the rising clock edge only while `wr_en` is high. With `wr_en` low, every register keeps its value.
- R9: While a write is in effect, a read port whose select equals the write destination shows `wr_data` in that same cycle.
- R10: While `rst_n` is low, all registers are cleared to zero, both read ports show zero, and no write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word supplying the read selects and the destination fields |
| dst_sel | input | 2 | Destination code: 00 rd field, 01 rt field, 10 link register 31, 11 none |
| wr_en | input | 1 | Write enable |
| wr_data | input | 32 | Data to write |
| rs_data | output | 32 | Operand read through instr[25:21] |
| rt_data | output | 32 | Operand read through instr[20:16] |

## Verification
The hardest cases to reach from the ports are those where one instruction word both selects a register for reading and names the same register as its write target. Examples are a link write that also reads register 31, an immediate-type write that targets its own rt read select, and a write aimed at register 0 while register 0 is being read. The stimulus table builds these overlapping fields on purpose and checks both ports in the write cycle. A later entry then reads the register back to show what was, or was not, stored. A reset asserted in the middle of the run is checked against registers that are already loaded.

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  localparam int AW    = $clog2(NREG),
  localparam int LINK  = NREG - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr,
  input  logic [1:0]        dst_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rs_data,
  output logic [DATA_W-1:0] rt_data
);

  logic [DATA_W-1:0] regs [NREG];
  logic [AW-1:0]     src_a, src_b, dest;
  logic              wr_hit;

  assign src_a = instr[21 +: AW];
  assign src_b = instr[16 +: AW];

  always_comb begin
    case (dst_sel)
      2'b00:   dest = instr[11 +: AW];
      2'b01:   dest = instr[16 +: AW];
      default: dest = AW'(LINK);
    endcase
  end

  assign wr_hit = rst_n && wr_en && (dst_sel != 2'b11) && (dest != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_hit) begin
      regs[dest] <= wr_data;
    end
  end

  function automatic logic [DATA_W-1:0] rd_port(input logic [AW-1:0] a);
    if (a == '0)                 return '0;
    else if (wr_hit && a == dest) return wr_data;
    else                          return regs[a];
  endfunction

  assign rs_data = rd_port(src_a);
  assign rt_data = rd_port(src_b);

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       instr,
  input logic [1:0]        dst_sel,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rs_data,
  input logic [DATA_W-1:0] rt_data
);

  logic [4:0] ck_dst;
  logic       ck_hit;

  assign ck_dst = (dst_sel == 2'b10) ? 5'd31 :
                  (dst_sel == 2'b01) ? instr[20:16] : instr[15:11];
  assign ck_hit = rst_n && wr_en && dst_sel != 2'b11 && ck_dst != 5'd0;

  a_r2_zero_rs: assert property (@(posedge clk) disable iff (!rst_n)
    instr[25:21] == 5'd0 |-> rs_data == '0);

  a_r2_zero_rt: assert property (@(posedge clk) disable iff (!rst_n)
    instr[20:16] == 5'd0 |-> rt_data == '0);

  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_hit && instr[25:21] == ck_dst) |-> rs_data == wr_data);

  a_r8_stored: assert property (@(posedge clk) disable iff (!rst_n)
    ck_hit |=> ((instr[25:21] == $past(ck_dst) &&
                 !(ck_hit && ck_dst == instr[25:21])) -> rs_data == $past(wr_data)));

  a_r10_reset: assert property (@(posedge clk)
    !rst_n |-> (rs_data == '0 && rt_data == '0));

endmodule

bind gpr_file gpr_file_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .dst_sel(dst_sel), .wr_en(wr_en),
  .wr_data(wr_data), .rs_data(rs_data), .rt_data(rt_data)
);

// File: tb/gpr_file_tb_top.sv
module gpr_file_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  dst_sel = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rs_data, rt_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  gpr_file dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .dst_sel(dst_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rs_data(rs_data), .rt_data(rt_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [4:0] rs, rt, rd);
    return {6'd0, rs, rt, rd, 5'd0, 6'd32};
  endfunction

  // {instr, dst_sel, wr_en, wr_data}
  localparam int NVEC = 12;
  localparam logic [66:0] VEC [NVEC] = '{
    {mk(5'd0, 5'd0, 5'd5),   2'b00, 1'b1, 32'hAAAA0005}, // R4 rd-field write
    {mk(5'd5, 5'd5, 5'd0),   2'b00, 1'b1, 32'hDEAD0000}, // R3 write to r0 dropped
    {mk(5'd0, 5'd9, 5'd3),   2'b01, 1'b1, 32'h12345678}, // R5 rt-field write, bypass on rt
    {mk(5'd9, 5'd31, 5'd4),  2'b10, 1'b1, 32'h00400008}, // R6 link write, bypass on rt
    {mk(5'd31, 5'd9, 5'd9),  2'b11, 1'b1, 32'hFFFFFFFF}, // R7 code 11 no write
    {mk(5'd31, 5'd9, 5'd31), 2'b00, 1'b0, 32'h0BADF00D}, // R8 enable low
    {mk(5'd0, 5'd0, 5'd9),   2'b01, 1'b1, 32'h77777777}, // R3 via rt select 0
    {mk(5'd7, 5'd7, 5'd7),   2'b00, 1'b1, 32'h13579BDF}, // R9 both ports bypass
    {mk(5'd7, 5'd7, 5'd2),   2'b01, 1'b1, 32'h2468ACE0}, // R5 overwrite r7
    {mk(5'd7, 5'd9, 5'd0),   2'b00, 1'b0, 32'h0},        // R1 two registers in parallel
    {mk(5'd5, 5'd31, 5'd31), 2'b00, 1'b1, 32'h0F0F0F0F}, // R4 rd=31, bypass on rt
    {mk(5'd31, 5'd0, 5'd6),  2'b10, 1'b0, 32'h0}         // R8 read back r31
  };

  function automatic logic [4:0] dst_of(input logic [31:0] ins, input logic [1:0] s);
    return (s == 2'b10) ? 5'd31 : (s == 2'b01) ? ins[20:16] : ins[15:11];
  endfunction

  function automatic logic hit_of(input logic [31:0] ins, input logic [1:0] s, input logic we);
    return we && s != 2'b11 && dst_of(ins, s) != 5'd0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a, input logic [31:0] ins,
                                         input logic [1:0] s, input logic we, input logic [31:0] d);
    if (a == 5'd0) return '0;
    if (hit_of(ins, s, we) && dst_of(ins, s) == a) return d;
    return model[a];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] a, input logic [31:0] ins,
                                   input logic [1:0] s, input logic we);
    if (a == 5'd0) return "R2 zero read";
    if (hit_of(ins, s, we) && dst_of(ins, s) == a) return "R9 bypass";
    return "R1/R8 stored read";
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [1:0] s, input logic we,
                       input logic [31:0] d);
    @(negedge clk);
    instr = ins; dst_sel = s; wr_en = we; wr_data = d;
    #2;
    check(tag_of(ins[25:21], ins, s, we), rs_data, exp_rd(ins[25:21], ins, s, we, d));
    check(tag_of(ins[20:16], ins, s, we), rt_data, exp_rd(ins[20:16], ins, s, we, d));
    @(posedge clk);
    if (hit_of(ins, s, we)) model[dst_of(ins, s)] = d;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    check("R10 rs in reset", rs_data, 32'h0);
    instr = mk(5'd4, 5'd4, 5'd4); wr_en = 1'b1; wr_data = 32'h55555555;
    #1;
    check("R10 no bypass in reset", rs_data, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R10 no write in reset", rt_data, 32'h0);
    wr_en = 1'b0;
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++)
      apply(VEC[v][66:35], VEC[v][34:33], VEC[v][32], VEC[v][31:0]);

    // R3: register 0 after writes aimed at it
    apply(mk(5'd0, 5'd0, 5'd0), 2'b00, 1'b0, 32'h0);
    // R7: r9 unchanged after code 11; R6: r31 holds last write
    apply(mk(5'd9, 5'd31, 5'd0), 2'b00, 1'b0, 32'h0);

    // R10: reset mid-run clears loaded registers
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 outputs during reset", rs_data | rt_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) model[i] = '0;
    apply(mk(5'd5, 5'd7, 5'd0), 2'b00, 1'b0, 32'h0);
    apply(mk(5'd9, 5'd31, 5'd0), 2'b00, 1'b0, 32'h0);
    check("R10 r9 cleared", rs_data, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule